// File: doc/BRIEF.md
# Pin Interrupt Unit

This block watches a small set of input pins, one per channel, and turns activity on each pin into an interrupt request on its own output line. Software chooses per channel whether the pin is watched for edges or for a level. In edge mode the channel can catch rising edges, falling edges or both. The catch is held as a pending flag until software acknowledges it. In level mode the output follows the pin for as long as the pin sits at the selected polarity and the channel is enabled.

Software reaches the unit through a plain register port with an address, a write strobe, write data and combinational read data. The two enable vectors can be loaded whole. Each also has a write-one-to-set alias and a write-one-to-clear alias, so one channel can be masked or unmasked without a read-modify-write. Two raw detect vectors record every edge seen, whether the channel is enabled or not. Pin inputs are synchronised with two flops before any detection.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every readable register reads 0 and `irq_o` is 0. Every channel starts in edge mode with both enables off.
- R2: Register 0x00 holds one mode bit per channel: 1 selects level detection and 0 selects edge detection. A write loads all bits and a read returns them.
- R3: 0x04 and 0x10 load the rising/level enable vector and the falling enable vector directly, and reads return them. 0x08 and 0x14 set, and 0x0C and 0x18 clear, only the bits written as 1. These four alias addresses read as 0.
- R4: An edge-mode channel with its rising enable set goes pending on a rising pin edge. `irq_o` rises on the third clock edge after the pin changes. An edge with no matching enable leaves the channel idle.
- R5: An edge-mode channel with its falling enable set goes pending on a falling edge. With both enables set it goes pending on either edge.
- R6: Writing 1 to bit n of status register 0x24 clears channel n's pending edge, and bits written 0 are kept. A new qualifying edge in the same cycle as the clear wins.
- R7: In level mode, channel n's output is its rising/level enable ANDed with the synchronised pin matching the polarity bit. The polarity bit is the falling enable: 1 means active high and 0 means active low. The output follows the pin two clock edges after the pin changes.
- R8: In level mode a status write has no effect and nothing is latched. A channel switched between modes starts with no pending edge.
- R9: Registers 0x1C and 0x20 set bit n on every rising or falling edge of pin n, whether or not the channel is enabled. Writing 1 to a bit clears it, and a new edge in the same cycle wins.
- R10: `irq_o` bit n equals bit n of the status register read at 0x24. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Asynchronous pin inputs, one per channel |
| addr_i | input | 8 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | NUM_CH | Interrupt request per channel |

## Verification
The bench targets four hazards:
- Latency: a design that skips or doubles a synchroniser stage raises the interrupt one edge early or late, and the exact-cycle checks on edge and level timing expose it.
- Aliases: aliases that write through instead of setting or clearing would wipe the neighbouring enable bits, and the readbacks after mixed set and clear writes reveal the lost bits.
- Level mode: a design that latches in level mode, or swaps the sense of the polarity bit, keeps the output high after the pin drops or asserts at the wrong level.
- Collisions: randomly placed write-one-to-clear writes meet fresh edges, and a design where the clear beats the set drops an edge the reference still shows pending.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // Register selector decoded from the byte address
    typedef enum logic [3:0] {
        SEL_MODE,
        SEL_RENA,
        SEL_RSET,
        SEL_RCLR,
        SEL_FENA,
        SEL_FSET,
        SEL_FCLR,
        SEL_RDET,
        SEL_FDET,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            8'h00:   s = SEL_MODE;
            8'h04:   s = SEL_RENA;
            8'h08:   s = SEL_RSET;
            8'h0C:   s = SEL_RCLR;
            8'h10:   s = SEL_FENA;
            8'h14:   s = SEL_FSET;
            8'h18:   s = SEL_FCLR;
            8'h1C:   s = SEL_RDET;
            8'h20:   s = SEL_FDET;
            8'h24:   s = SEL_STAT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Next value of an enable vector given its direct, set and clear selectors
    function automatic logic [DATA_W-1:0] next_enable(
        input wr_cmd_t           cmd,
        input reg_sel_e          sel_load,
        input reg_sel_e          sel_set,
        input reg_sel_e          sel_clr,
        input logic [DATA_W-1:0] old
    );
        logic [DATA_W-1:0] n;
        n = old;
        if (cmd.we) begin
            if (cmd.sel == sel_load)      n = cmd.data;
            else if (cmd.sel == sel_set)  n = old | cmd.data;
            else if (cmd.sel == sel_clr)  n = old & ~cmd.data;
        end
        return n;
    endfunction

    // Sticky capture with write-one-to-clear; a new event wins
    function automatic logic [DATA_W-1:0] sticky_next(
        input logic [DATA_W-1:0] old,
        input logic [DATA_W-1:0] clr,
        input logic [DATA_W-1:0] evt
    );
        return (old & ~clr) | evt;
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int STAGES = 2;

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur_o  = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pin_irq_channel.sv
module pin_irq_channel (
    input  logic clk,
    input  logic rst,
    input  logic level_mode_i,
    input  logic en_rise_i,
    input  logic en_fall_i,
    input  logic cur_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic stat_clr_i,
    output logic status_o
);
    logic pend_q;
    logic edge_hit;
    logic level_hit;

    assign edge_hit  = (rise_i & en_rise_i) | (fall_i & en_fall_i);   // R4 R5
    assign level_hit = en_rise_i & (cur_i == en_fall_i);              // R7

    always_ff @(posedge clk) begin
        if (rst)               pend_q <= 1'b0;
        else if (level_mode_i) pend_q <= 1'b0;                        // R8
        else                   pend_q <= (pend_q & ~stat_clr_i) | edge_hit; // R6
    end

    assign status_o = level_mode_i ? level_hit : pend_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd_i,
    input  logic [NUM_CH-1:0] rise_ev_i,
    input  logic [NUM_CH-1:0] fall_ev_i,
    output logic [NUM_CH-1:0] mode_o,
    output logic [NUM_CH-1:0] ena_rise_o,
    output logic [NUM_CH-1:0] ena_fall_o,
    output logic [NUM_CH-1:0] rise_det_o,
    output logic [NUM_CH-1:0] fall_det_o,
    output logic [NUM_CH-1:0] stat_clr_o
);
    logic [NUM_CH-1:0] wdata;
    logic [NUM_CH-1:0] rdet_clr;
    logic [NUM_CH-1:0] fdet_clr;
    logic [DATA_W-1:0] er_next;
    logic [DATA_W-1:0] ef_next;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] fd_next;

    assign wdata      = cmd_i.data[NUM_CH-1:0];
    assign rdet_clr   = (cmd_i.we && cmd_i.sel == SEL_RDET) ? wdata : '0;
    assign fdet_clr   = (cmd_i.we && cmd_i.sel == SEL_FDET) ? wdata : '0;
    assign stat_clr_o = (cmd_i.we && cmd_i.sel == SEL_STAT) ? wdata : '0;

    assign er_next = next_enable(cmd_i, SEL_RENA, SEL_RSET, SEL_RCLR, DATA_W'(ena_rise_o)); // R3
    assign ef_next = next_enable(cmd_i, SEL_FENA, SEL_FSET, SEL_FCLR, DATA_W'(ena_fall_o)); // R3
    assign rd_next = sticky_next(DATA_W'(rise_det_o), DATA_W'(rdet_clr), DATA_W'(rise_ev_i)); // R9
    assign fd_next = sticky_next(DATA_W'(fall_det_o), DATA_W'(fdet_clr), DATA_W'(fall_ev_i)); // R9

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o     <= '0;
            ena_rise_o <= '0;
            ena_fall_o <= '0;
            rise_det_o <= '0;
            fall_det_o <= '0;
        end else begin
            if (cmd_i.we && cmd_i.sel == SEL_MODE) mode_o <= wdata;   // R2
            ena_rise_o <= er_next[NUM_CH-1:0];
            ena_fall_o <= ef_next[NUM_CH-1:0];
            rise_det_o <= rd_next[NUM_CH-1:0];
            fall_det_o <= fd_next[NUM_CH-1:0];
        end
    end
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [7:0]        addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    output logic [NUM_CH-1:0] irq_o
);
    wr_cmd_t           cmd;
    reg_sel_e          rsel;
    logic [NUM_CH-1:0] pin_cur;
    logic [NUM_CH-1:0] rise_ev;
    logic [NUM_CH-1:0] fall_ev;
    logic [NUM_CH-1:0] mode_q;
    logic [NUM_CH-1:0] ena_rise_q;
    logic [NUM_CH-1:0] ena_fall_q;
    logic [NUM_CH-1:0] rise_det_q;
    logic [NUM_CH-1:0] fall_det_q;
    logic [NUM_CH-1:0] stat_clr;
    logic [NUM_CH-1:0] status;

    assign rsel     = decode_sel(addr_i);
    assign cmd.we   = wr_en_i;
    assign cmd.sel  = rsel;
    assign cmd.data = wr_data_i;

    pin_irq_sync #(.W(NUM_CH)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (pin_i),
        .cur_o (pin_cur),
        .rise_o(rise_ev),
        .fall_o(fall_ev)
    );

    pin_irq_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .rise_ev_i (rise_ev),
        .fall_ev_i (fall_ev),
        .mode_o    (mode_q),
        .ena_rise_o(ena_rise_q),
        .ena_fall_o(ena_fall_q),
        .rise_det_o(rise_det_q),
        .fall_det_o(fall_det_q),
        .stat_clr_o(stat_clr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pin_irq_channel i_ch (
            .clk         (clk),
            .rst         (rst),
            .level_mode_i(mode_q[n]),
            .en_rise_i   (ena_rise_q[n]),
            .en_fall_i   (ena_fall_q[n]),
            .cur_i       (pin_cur[n]),
            .rise_i      (rise_ev[n]),
            .fall_i      (fall_ev[n]),
            .stat_clr_i  (stat_clr[n]),
            .status_o    (status[n])
        );
    end

    assign irq_o = status;   // R10

    always_comb begin
        rd_data_o = '0;
        case (rsel)
            SEL_MODE: rd_data_o = DATA_W'(mode_q);
            SEL_RENA: rd_data_o = DATA_W'(ena_rise_q);
            SEL_FENA: rd_data_o = DATA_W'(ena_fall_q);
            SEL_RDET: rd_data_o = DATA_W'(rise_det_q);
            SEL_FDET: rd_data_o = DATA_W'(fall_det_q);
            SEL_STAT: rd_data_o = DATA_W'(status);
            default:  rd_data_o = '0;   // aliases and unmapped, R3 R10
        endcase
    end
endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        addr_i,
    input logic              wr_en_i,
    input logic [31:0]       wr_data_i,
    input logic [NUM_CH-1:0] irq_o,
    input logic [NUM_CH-1:0] mode_q,
    input logic [NUM_CH-1:0] ena_rise_q,
    input logic [NUM_CH-1:0] ena_fall_q,
    input logic [NUM_CH-1:0] rise_det_q,
    input logic [NUM_CH-1:0] rise_ev,
    input logic [NUM_CH-1:0] fall_ev
);
    logic [NUM_CH-1:0] wd;
    logic [NUM_CH-1:0] rdet_wclr;

    assign wd        = wr_data_i[NUM_CH-1:0];
    assign rdet_wclr = (wr_en_i && addr_i == 8'h1C) ? wd : '0;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_o == '0));

    a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 8'h08) |=> ((ena_rise_q & $past(wd)) == $past(wd)));

    a_r3_clear_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 8'h0C) |=> ((ena_rise_q & $past(wd)) == '0));

    a_r4_edge_needs_cause: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((irq_o & ~$past(irq_o) & ~mode_q & ~$past(mode_q)
                   & ~$past((rise_ev & ena_rise_q) | (fall_ev & ena_fall_q))) == '0));

    a_r7_level_masked: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & mode_q & ~ena_rise_q) == '0));

    a_r9_detect_sticky: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(rise_det_q) & ~$past(rdet_wclr) & ~rise_det_q) == '0));
endmodule

bind pin_irq_unit pin_irq_checker #(.NUM_CH(NUM_CH)) i_pin_irq_checker (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o),
    .mode_q    (mode_q),
    .ena_rise_q(ena_rise_q),
    .ena_fall_q(ena_fall_q),
    .rise_det_q(rise_det_q),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev)
);

// File: tb/test_pin_irq_unit.sv
module test_pin_irq_unit;
    localparam int NC = 8;
    localparam int RAND_STEPS = 4000;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] pins = '0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rd_data;
    logic [NC-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pin_irq_unit #(.NUM_CH(NC)) i_pin_irq_unit (
        .clk(clk), .rst(rst), .pin_i(pins), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
    );

    // Reference state built from the requirements
    logic [NC-1:0] m_s1, m_s2, m_prev, m_mode, m_er, m_ef, m_rd, m_fd, m_pend;

    always @(posedge clk) begin
        logic [NC-1:0] rise, fall, d, clr_st, clr_rd, clr_fd;
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_mode <= '0; m_er <= '0;
            m_ef <= '0; m_rd <= '0; m_fd <= '0; m_pend <= '0;
        end else begin
            rise = m_s2 & ~m_prev;
            fall = ~m_s2 & m_prev;
            d = wdata[NC-1:0];
            clr_st = (wr_en && addr == 8'h24) ? d : '0;
            clr_rd = (wr_en && addr == 8'h1C) ? d : '0;
            clr_fd = (wr_en && addr == 8'h20) ? d : '0;
            m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
            if (wr_en) begin
                case (addr)
                    8'h00: m_mode <= d;
                    8'h04: m_er <= d;
                    8'h08: m_er <= m_er | d;
                    8'h0C: m_er <= m_er & ~d;
                    8'h10: m_ef <= d;
                    8'h14: m_ef <= m_ef | d;
                    8'h18: m_ef <= m_ef & ~d;
                    default: ;
                endcase
            end
            m_rd <= (m_rd & ~clr_rd) | rise;
            m_fd <= (m_fd & ~clr_fd) | fall;
            for (int n = 0; n < NC; n++)
                m_pend[n] <= m_mode[n] ? 1'b0
                           : ((m_pend[n] & ~clr_st[n]) | (rise[n] & m_er[n]) | (fall[n] & m_ef[n]));
        end
    end

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int n = 0; n < NC; n++)
            r[n] = m_mode[n] ? (m_er[n] & (m_s2[n] == m_ef[n])) : m_pend[n];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return 32'(m_mode);
            8'h04: return 32'(m_er);
            8'h10: return 32'(m_ef);
            8'h1C: return 32'(m_rd);
            8'h20: return 32'(m_fd);
            8'h24: return 32'(exp_irq());
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18: return "R3";
            8'h1C, 8'h20: return "R9";
            8'h24: return "R10";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs at the falling edge, then compare with the reference
    task automatic step(input logic [NC-1:0] p, input logic we, input logic [7:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        pins = p; wr_en = we; addr = a; wdata = d;
        #2;
        check("R4/R5/R6/R7/R8", 32'(irq), 32'(exp_irq()));
        check(tag_of(a), rd_data, exp_read(a));
    endtask

    initial begin
        #(WATCHDOG * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: everything reads zero
        for (int i = 0; i < 10; i++) begin
            step('0, 1'b0, 8'(i * 4), '0);
            check("R1", rd_data, 32'h0);
            check("R1", 32'(irq), 32'h0);
        end

        // R3: direct load, set and clear aliases
        step('0, 1'b1, 8'h04, 32'h0F);
        step('0, 1'b1, 8'h08, 32'h30);
        step('0, 1'b1, 8'h0C, 32'h03);
        step('0, 1'b0, 8'h04, '0);
        check("R3", rd_data, 32'h3C);
        step('0, 1'b0, 8'h08, '0);
        check("R3", rd_data, 32'h0);

        // R2: mode register
        step('0, 1'b1, 8'h00, 32'hA5);
        step('0, 1'b0, 8'h00, '0);
        check("R2", rd_data, 32'hA5);
        step('0, 1'b1, 8'h00, 32'h00);

        step('0, 1'b1, 8'h04, 32'h01);
        step('0, 1'b1, 8'h10, 32'h00);
        step('0, 1'b1, 8'h24, 32'hFF);

        // R4: rising edge on pin 0, exact latency
        step(8'h01, 1'b0, 8'h24, '0);
        check("R4", 32'(irq), 32'h0);
        step(8'h01, 1'b0, 8'h24, '0);
        step(8'h01, 1'b0, 8'h24, '0);
        check("R4", 32'(irq), 32'h0);
        step(8'h01, 1'b0, 8'h24, '0);
        check("R4", 32'(irq), 32'h1);
        check("R10", rd_data, 32'h1);

        // R6: write-one-to-clear status
        step(8'h01, 1'b1, 8'h24, 32'h01);
        step(8'h01, 1'b0, 8'h24, '0);
        check("R6", 32'(irq), 32'h0);

        // R5: falling enable on channel 1 ignores the rise, catches the fall
        step(8'h01, 1'b1, 8'h10, 32'h02);
        step(8'h03, 1'b0, 8'h24, '0);
        step(8'h03, 1'b0, 8'h24, '0);
        step(8'h03, 1'b0, 8'h24, '0);
        step(8'h03, 1'b0, 8'h24, '0);
        check("R5", 32'(irq), 32'h0);
        // R9: raw rise capture regardless of enable
        step(8'h03, 1'b0, 8'h1C, '0);
        check("R9", rd_data, 32'h03);
        step(8'h01, 1'b0, 8'h24, '0);
        step(8'h01, 1'b0, 8'h24, '0);
        step(8'h01, 1'b0, 8'h24, '0);
        step(8'h01, 1'b0, 8'h24, '0);
        check("R5", 32'(irq), 32'h2);
        step(8'h01, 1'b0, 8'h20, '0);
        check("R9", rd_data, 32'h02);
        step(8'h01, 1'b1, 8'h20, 32'h02);
        step(8'h01, 1'b0, 8'h20, '0);
        check("R9", rd_data, 32'h0);

        // R7: level mode on channel 3, active high then active low
        step(8'h01, 1'b1, 8'h00, 32'h08);
        step(8'h01, 1'b1, 8'h08, 32'h08);
        step(8'h01, 1'b1, 8'h14, 32'h08);
        step(8'h09, 1'b0, 8'h24, '0);
        check("R7", 32'(irq & 8'h08), 32'h0);
        step(8'h09, 1'b0, 8'h24, '0);
        step(8'h09, 1'b0, 8'h24, '0);
        check("R7", 32'(irq & 8'h08), 32'h08);
        // R8: status write has no effect in level mode
        step(8'h09, 1'b1, 8'h24, 32'h08);
        step(8'h09, 1'b0, 8'h24, '0);
        check("R8", 32'(irq & 8'h08), 32'h08);
        step(8'h09, 1'b1, 8'h18, 32'h08);
        step(8'h09, 1'b0, 8'h24, '0);
        check("R7", 32'(irq & 8'h08), 32'h0);
        step(8'h01, 1'b0, 8'h24, '0);
        step(8'h01, 1'b0, 8'h24, '0);
        step(8'h01, 1'b0, 8'h24, '0);
        check("R7", 32'(irq & 8'h08), 32'h08);

        // Random phase against the reference
        for (int k = 0; k < RAND_STEPS; k++) begin
            logic [NC-1:0] p;
            p = pins;
            for (int b = 0; b < NC; b++)
                if ($urandom_range(7) == 0) p[b] = ~p[b];
            step(p, ($urandom_range(3) == 0), 8'($urandom_range(10) * 4), $urandom());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule